// File: doc/BRIEF.md
# Minimal Load-Store Processor Core

This block is a small sequential processor. It runs a compact load-store instruction set. It fetches one 16-bit instruction per cycle from an instruction memory that reads combinationally. It keeps eight 16-bit general registers, one program counter and a set of compare flags. It reaches a synchronous data memory through a direct-addressed port. Arithmetic, logic and shift operations read a source register and a second operand, and write a destination register. The second operand is either a small zero-extended immediate or a third register.

Conditional branches do not look at arithmetic results. They test only the outcome that the most recent compare latched. A halt instruction freezes the core until the next reset. The block suits small sequencing jobs, where a fixed program in a local ROM moves and combines words in a local RAM.

Top module: `mini_ls_core`

## Requirements
- R1: While `rstN` is low and after it is released, the program counter is 0, all eight registers read as 0, all compare flags are clear and `halted` is low.
- R2: An instruction word splits into these fields: [15:11] opcode, [10:8] destination register, [7:5] first source register, [4] operand select, [3:0] immediate (the second register is [2:0]). Loads, stores and branches take an 8-bit address from [7:0]. The opcodes are 1 load, 2 store, 3 move, 4 invert, 5 add, 6 subtract, 7 and, 8 or, 9 xor, 10 shift left, 11 shift right, 12 compare, 13 jump, 14 branch-equal, 15 branch-not-equal, 16 branch-greater, 17 branch-less, 18 halt.
- R3: When the operand-select bit is 1, the second operand is the register named in [2:0]. When it is 0, the second operand is the 4-bit immediate, zero-extended.
- R4: Add writes first source plus operand, and subtract writes first source minus operand. Both wrap modulo 2^16.
- R5: The and, or and xor operations combine the first source with the operand bit by bit. Move writes the operand and invert writes its bitwise complement. Neither move nor invert reads the first source.
- R6: Shift left and shift right move the first source by the operand amount and fill vacated bits with zeros. An amount of 16 or more gives 0.
- R7: A load writes the data memory word at the address into the destination register. It takes two cycles, because the memory returns read data one cycle after the address.
- R8: A store drives the destination register's value and the address, with `dmemWe` high for exactly one cycle. It takes one cycle and writes no other location.
- R9: Compare writes no register. It latches exactly one unsigned outcome (equal, greater or less) of first source against operand. The flags change only on a compare.
- R10: A jump always loads the address into the program counter. Branch-equal, branch-not-equal, branch-greater and branch-less load the address only when the latched outcome matches, and otherwise fall through.
- R11: After halt, the program counter, the registers and the data memory stay unchanged, `dmemWe` stays low and `halted` stays high until reset.
- R12: An opcode outside the defined set (0, or 19 to 31) changes no register and no flag, and advances the program counter by one in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| imemAddr | output | 8 | Program counter, the instruction fetch address |
| imemData | input | 16 | Instruction word at imemAddr, same cycle |
| dmemAddr | output | 8 | Data memory address for loads and stores |
| dmemWdata | output | 16 | Store data |
| dmemRdata | input | 16 | Read data, valid one cycle after the address |
| dmemWe | output | 1 | Data memory write enable |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Register contents cannot be seen directly. A wrong register value or a wrong flag therefore shows up at the ports only when a later store puts the register on `dmemWdata`, or when a later branch sends `imemAddr` to the wrong place. Each program therefore ends by storing every result it touched. A missed or extra wait cycle on loads shifts the moment `halted` rises, so the cycle count from reset release to halt is compared against the sum of instruction lengths. A freeze failure shows on the first cycle after halt, as a moving `imemAddr` or a write strobe.

// File: rtl/mls_pkg.sv
package mls_pkg;

  localparam int INSTR_W = 16;
  localparam int OP_W    = 5;
  localparam int RIDX_W  = 3;
  localparam int IMM_W   = 4;
  localparam int ADDR_W  = 8;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 5'd1,
    OP_STORE = 5'd2,
    OP_MOVE  = 5'd3,
    OP_INV   = 5'd4,
    OP_ADD   = 5'd5,
    OP_SUB   = 5'd6,
    OP_AND   = 5'd7,
    OP_OR    = 5'd8,
    OP_XOR   = 5'd9,
    OP_SHL   = 5'd10,
    OP_SHR   = 5'd11,
    OP_CMP   = 5'd12,
    OP_JMP   = 5'd13,
    OP_BEQ   = 5'd14,
    OP_BNE   = 5'd15,
    OP_BGT   = 5'd16,
    OP_BLT   = 5'd17,
    OP_HALT  = 5'd18
  } opcode_t;

  typedef struct packed {
    logic regWe;   // write destination register
    logic wbMem;   // write-back source is data memory
    logic flagWe;  // latch compare outcome
    logic pcLoad;  // load program counter with address field
    logic pcHold;  // keep program counter
  } ctlStrobes_t;

endpackage

// File: rtl/mls_alu.sv
module mls_alu
  import mls_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opcode_t           op,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result
);

  localparam int SH_W = $clog2(DATA_W);

  logic              shiftOver;
  logic [SH_W-1:0]   shiftAmt;

  assign shiftOver = (srcB >= DATA_W'(DATA_W));
  assign shiftAmt  = srcB[SH_W-1:0];

  always_comb begin
    unique case (op)
      OP_MOVE: result = srcB;
      OP_INV:  result = ~srcB;
      OP_ADD:  result = srcA + srcB;
      OP_SUB:  result = srcA - srcB;
      OP_AND:  result = srcA & srcB;
      OP_OR:   result = srcA | srcB;
      OP_XOR:  result = srcA ^ srcB;
      OP_SHL:  result = shiftOver ? '0 : (srcA << shiftAmt);
      OP_SHR:  result = shiftOver ? '0 : (srcA >> shiftAmt);
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/mls_control.sv
module mls_control
  import mls_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  opcode_t     op,
  input  logic        flagEq,
  input  logic        flagGt,
  input  logic        flagLt,
  output ctlStrobes_t strobes,
  output logic        memWe,
  output logic        halted
);

  typedef enum logic [1:0] {ST_RUN, ST_LOAD, ST_HALT} state_t;

  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_RUN: begin
        unique case (op)
          OP_LOAD: begin
            strobes.pcHold = 1'b1;
            stateNext      = ST_LOAD;
          end
          OP_MOVE, OP_INV, OP_ADD, OP_SUB, OP_AND,
          OP_OR, OP_XOR, OP_SHL, OP_SHR:
            strobes.regWe = 1'b1;
          OP_CMP:  strobes.flagWe = 1'b1;
          OP_JMP:  strobes.pcLoad = 1'b1;
          OP_BEQ:  strobes.pcLoad = flagEq;
          OP_BNE:  strobes.pcLoad = ~flagEq;
          OP_BGT:  strobes.pcLoad = flagGt;
          OP_BLT:  strobes.pcLoad = flagLt;
          OP_HALT: begin
            strobes.pcHold = 1'b1;
            stateNext      = ST_HALT;
          end
          default: ;
        endcase
      end
      ST_LOAD: begin
        strobes.regWe = 1'b1;
        strobes.wbMem = 1'b1;
        stateNext     = ST_RUN;
      end
      default: strobes.pcHold = 1'b1;
    endcase
  end

  assign memWe  = (state == ST_RUN) && (op == OP_STORE);
  assign halted = (state == ST_HALT);

  AST_LOAD_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |=> (state == ST_RUN)); // R7
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted); // R11
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!strobes.regWe && !strobes.flagWe && !memWe)); // R11

endmodule

// File: rtl/mls_datapath.sv
module mls_datapath
  import mls_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instr,
  input  ctlStrobes_t        strobes,
  input  logic [DATA_W-1:0]  memRdata,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  output logic               flagEq,
  output logic               flagGt,
  output logic               flagLt
);

  localparam int REG_N = 2 ** RIDX_W;

  opcode_t           op;
  logic [RIDX_W-1:0] rdIdx, rnIdx, rmIdx;
  logic              useReg;
  logic [IMM_W-1:0]  immVal;
  logic [ADDR_W-1:0] addrField;

  assign op        = opcode_t'(instr[INSTR_W-1 -: OP_W]);
  assign rdIdx     = instr[INSTR_W-OP_W-1 -: RIDX_W];
  assign rnIdx     = instr[INSTR_W-OP_W-RIDX_W-1 -: RIDX_W];
  assign useReg    = instr[IMM_W];
  assign immVal    = instr[IMM_W-1:0];
  assign rmIdx     = instr[RIDX_W-1:0];
  assign addrField = instr[ADDR_W-1:0];

  logic [DATA_W-1:0] regs [REG_N];
  logic [DATA_W-1:0] srcA, srcB, aluOut, wbData;

  assign srcA     = regs[rnIdx];
  assign srcB     = useReg ? regs[rmIdx] : DATA_W'(immVal);
  assign memAddr  = addrField;
  assign memWdata = regs[rdIdx];

  mls_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (op),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (aluOut)
  );

  assign wbData = strobes.wbMem ? memRdata : aluOut;

  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regs[i] <= '0;
      else if (strobes.regWe && (rdIdx == RIDX_W'(i)))
        regs[i] <= wbData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagEq <= 1'b0;
      flagGt <= 1'b0;
      flagLt <= 1'b0;
    end else if (strobes.flagWe) begin
      flagEq <= (srcA == srcB);
      flagGt <= (srcA > srcB);
      flagLt <= (srcA < srcB);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                pc <= '0;
    else if (strobes.pcLoad)  pc <= addrField;
    else if (!strobes.pcHold) pc <= pc + 1'b1;
  end

  AST_FLAGS_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagWe |=> ($countones({flagEq, flagGt, flagLt}) == 1)); // R9
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pcLoad |=> (pc == $past(addrField))); // R10
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.flagWe && $past(rstN)) |=> $stable({flagEq, flagGt, flagLt})); // R9

endmodule

// File: rtl/mini_ls_core.sv
module mini_ls_core
  import mls_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  output logic [ADDR_W-1:0]  imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  output logic [ADDR_W-1:0]  dmemAddr,
  output logic [DATA_W-1:0]  dmemWdata,
  input  logic [DATA_W-1:0]  dmemRdata,
  output logic               dmemWe,
  output logic               halted
);

  ctlStrobes_t strobes;
  logic        flagEq, flagGt, flagLt;

  mls_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .op      (opcode_t'(imemData[INSTR_W-1 -: OP_W])),
    .flagEq  (flagEq),
    .flagGt  (flagGt),
    .flagLt  (flagLt),
    .strobes (strobes),
    .memWe   (dmemWe),
    .halted  (halted)
  );

  mls_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .instr    (imemData),
    .strobes  (strobes),
    .memRdata (dmemRdata),
    .pc       (imemAddr),
    .memAddr  (dmemAddr),
    .memWdata (dmemWdata),
    .flagEq   (flagEq),
    .flagGt   (flagGt),
    .flagLt   (flagLt)
  );

  AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(imemAddr)); // R11
  AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !dmemWe); // R11
  AST_STORE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    dmemWe |=> (imemAddr == ADDR_W'($past(imemAddr) + 1'b1))); // R8

endmodule

// File: tb/mini_ls_core_tb.sv
module mini_ls_core_tb;

  localparam int OP_LD = 1, OP_ST = 2, OP_MV = 3, OP_NT = 4, OP_AD = 5, OP_SB = 6,
                 OP_AN = 7, OP_OR = 8, OP_XR = 9, OP_SL = 10, OP_SR = 11, OP_CP = 12,
                 OP_JP = 13, OP_EQ = 14, OP_NE = 15, OP_GT = 16, OP_LT = 17, OP_HL = 18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  imemAddr, dmemAddr;
  logic [15:0] imemData, dmemWdata, dmemRdata;
  logic        dmemWe, halted;

  logic [15:0] im [256];
  logic [15:0] dm [256];

  int nTests = 0;
  int nFail  = 0;
  int runCyc, runWe;

  always #5 clk = ~clk;

  mini_ls_core u_dut (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWdata(dmemWdata), .dmemRdata(dmemRdata),
    .dmemWe(dmemWe), .halted(halted)
  );

  assign imemData = im[imemAddr];

  always @(posedge clk) begin
    if (dmemWe) dm[dmemAddr] <= dmemWdata;
    dmemRdata <= dm[dmemAddr];
  end

  function automatic logic [15:0] encR(input int op, input int rd, input int rn,
                                       input int sel, input int low);
    return {op[4:0], rd[2:0], rn[2:0], sel[0], low[3:0]};
  endfunction

  function automatic logic [15:0] encA(input int op, input int rd, input int addr);
    return {op[4:0], rd[2:0], addr[7:0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) begin
      im[i] = encR(OP_HL, 0, 0, 0, 0);
      dm[i] = 16'hDEAD;
    end
  endtask

  task automatic runProg();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN   = 1'b1;
    runCyc = 0;
    runWe  = 0;
    while (!halted && runCyc < 500) begin
      if (dmemWe) runWe++;
      @(posedge clk);
      #1;
      runCyc++;
    end
  endtask

  task automatic tReset();
    clearMem();
    for (int r = 0; r < 8; r++) im[r] = encA(OP_ST, r, 8'h80 + r);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 halted low in reset", {15'd0, halted}, 16'd0);
    check("R1 pc zero in reset", {8'd0, imemAddr}, 16'd0);
    runProg();
    for (int r = 0; r < 8; r++) check("R1 register cleared", dm[8'h80 + r], 16'h0000);
  endtask

  task automatic tArith();
    clearMem();
    im[0] = encR(OP_MV, 1, 0, 0, 9);
    im[1] = encR(OP_MV, 2, 0, 0, 15);
    im[2] = encR(OP_AD, 3, 1, 1, 2);   // R3 register operand
    im[3] = encR(OP_SB, 4, 1, 0, 10);  // R4 wrap below zero
    im[4] = encR(OP_AD, 5, 4, 0, 2);   // R4 wrap above max
    im[5] = encA(OP_ST, 3, 8'h40);
    im[6] = encA(OP_ST, 4, 8'h41);
    im[7] = encA(OP_ST, 5, 8'h42);
    runProg();
    check("R3 R2 add with register operand", dm[8'h40], 16'd24);
    check("R4 subtract wraps", dm[8'h41], 16'hFFFF);
    check("R4 add wraps", dm[8'h42], 16'h0001);
    check("R2 cycle count single-cycle ops", 16'(runCyc), 16'd9);
  endtask

  task automatic tLogic();
    clearMem();
    dm[8'h10] = 16'hF0F0;
    dm[8'h11] = 16'h3C3C;
    im[0]  = encA(OP_LD, 1, 8'h10);
    im[1]  = encA(OP_LD, 2, 8'h11);
    im[2]  = encR(OP_AN, 3, 1, 1, 2);
    im[3]  = encR(OP_OR, 4, 1, 1, 2);
    im[4]  = encR(OP_XR, 5, 1, 1, 2);
    im[5]  = encR(OP_NT, 6, 7, 1, 2);  // Rn field points elsewhere, unused
    im[6]  = encR(OP_NT, 7, 1, 0, 5);
    im[7]  = encR(OP_MV, 0, 5, 1, 1);
    im[8]  = encA(OP_ST, 0, 8'h50);
    im[9]  = encA(OP_ST, 3, 8'h53);
    im[10] = encA(OP_ST, 4, 8'h54);
    im[11] = encA(OP_ST, 5, 8'h55);
    im[12] = encA(OP_ST, 6, 8'h56);
    im[13] = encA(OP_ST, 7, 8'h57);
    runProg();
    check("R7 R5 move from loaded register", dm[8'h50], 16'hF0F0);
    check("R5 and", dm[8'h53], 16'h3030);
    check("R5 or", dm[8'h54], 16'hFCFC);
    check("R5 xor", dm[8'h55], 16'hCCCC);
    check("R5 invert register", dm[8'h56], 16'hC3C3);
    check("R5 invert immediate", dm[8'h57], 16'hFFFA);
    check("R7 load takes two cycles", 16'(runCyc), 16'd17);
    check("R8 one strobe per store", 16'(runWe), 16'd6);
    check("R8 neighbour untouched", dm[8'h51], 16'hDEAD);
  endtask

  task automatic tShift();
    clearMem();
    dm[8'h10] = 16'hF0F0;
    im[0]  = encA(OP_LD, 1, 8'h10);
    im[1]  = encR(OP_SL, 2, 1, 0, 4);
    im[2]  = encR(OP_SR, 3, 1, 0, 12);
    im[3]  = encR(OP_MV, 4, 0, 0, 15);
    im[4]  = encR(OP_AD, 4, 4, 0, 1);
    im[5]  = encR(OP_SL, 5, 1, 1, 4);
    im[6]  = encR(OP_SR, 6, 1, 1, 4);
    im[7]  = encR(OP_MV, 0, 0, 0, 3);
    im[8]  = encR(OP_SR, 7, 1, 1, 0);
    im[9]  = encA(OP_ST, 2, 8'h60);
    im[10] = encA(OP_ST, 3, 8'h61);
    im[11] = encA(OP_ST, 5, 8'h62);
    im[12] = encA(OP_ST, 6, 8'h63);
    im[13] = encA(OP_ST, 7, 8'h64);
    runProg();
    check("R6 shift left zero fill", dm[8'h60], 16'h0F00);
    check("R6 shift right zero fill", dm[8'h61], 16'h000F);
    check("R6 shift left by 16 gives zero", dm[8'h62], 16'h0000);
    check("R6 shift right by 16 gives zero", dm[8'h63], 16'h0000);
    check("R6 shift by register amount", dm[8'h64], 16'h1E1E);
  endtask

  task automatic tBranch();
    clearMem();
    im[0]  = encR(OP_MV, 1, 0, 0, 5);
    im[1]  = encR(OP_CP, 0, 1, 0, 7);    // less
    im[2]  = encA(OP_LT, 0, 4);
    im[3]  = encR(OP_MV, 6, 0, 0, 1);
    im[4]  = encA(OP_GT, 0, 6);
    im[5]  = encR(OP_OR, 7, 7, 0, 1);
    im[6]  = encA(OP_EQ, 0, 8);
    im[7]  = encR(OP_OR, 7, 7, 0, 2);
    im[8]  = encR(OP_SB, 3, 1, 0, 5);    // zero result, flags keep "less"
    im[9]  = encA(OP_NE, 0, 11);
    im[10] = encR(OP_MV, 6, 0, 0, 2);
    im[11] = encR(OP_CP, 0, 1, 1, 1);    // equal
    im[12] = encA(OP_EQ, 0, 14);
    im[13] = encR(OP_MV, 6, 0, 0, 3);
    im[14] = encR(OP_CP, 0, 1, 0, 3);    // greater
    im[15] = encA(OP_GT, 0, 17);
    im[16] = encR(OP_MV, 6, 0, 0, 4);
    im[17] = encR(OP_NT, 2, 0, 0, 0);
    im[18] = encR(OP_CP, 0, 2, 0, 1);    // 0xFFFF vs 1: unsigned greater
    im[19] = encA(OP_LT, 0, 21);
    im[20] = encR(OP_OR, 7, 7, 0, 4);
    im[21] = encA(OP_JP, 0, 23);
    im[22] = encR(OP_MV, 6, 0, 0, 5);
    im[23] = encA(OP_ST, 6, 8'hA0);
    im[24] = encA(OP_ST, 7, 8'hA1);
    im[25] = encA(OP_ST, 1, 8'hA3);
    runProg();
    check("R10 taken branches skip bad paths", dm[8'hA0], 16'h0000);
    check("R10 untaken branches fall through", dm[8'hA1], 16'h0007);
    check("R9 compare writes no register", dm[8'hA3], 16'h0005);
    check("R9 R10 cycle count", 16'(runCyc), 16'd22);
  endtask

  task automatic tHalt();
    clearMem();
    im[0] = encR(OP_MV, 1, 0, 0, 1);
    im[1] = encA(OP_ST, 1, 8'hB0);
    im[2] = encR(OP_HL, 0, 0, 0, 0);
    im[3] = encA(OP_ST, 1, 8'hB1);
    runProg();
    check("R11 halted raised", {15'd0, halted}, 16'd1);
    check("R11 halt cycle", 16'(runCyc), 16'd3);
    begin
      int moved = 0;
      int wrote = 0;
      for (int c = 0; c < 10; c++) begin
        @(posedge clk);
        #1;
        if (imemAddr != 8'd2) moved++;
        if (dmemWe || !halted) wrote++;
      end
      check("R11 pc frozen", 16'(moved), 16'd0);
      check("R11 no write while halted", 16'(wrote), 16'd0);
    end
    check("R11 store before halt", dm[8'hB0], 16'h0001);
    check("R11 store after halt skipped", dm[8'hB1], 16'hDEAD);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    check("R1 R11 reset clears halt", {15'd0, halted}, 16'd0);
  endtask

  task automatic tUndef();
    clearMem();
    im[0] = encR(OP_MV, 1, 0, 0, 4);
    im[1] = encR(OP_CP, 0, 1, 0, 4);    // equal
    im[2] = 16'hFFFF;                    // opcode 31
    im[3] = 16'h0000;                    // opcode 0
    im[4] = encR(19, 1, 1, 0, 9);        // opcode 19
    im[5] = encA(OP_EQ, 0, 7);
    im[6] = encR(OP_MV, 6, 0, 0, 1);
    im[7] = encA(OP_ST, 1, 8'hC0);
    im[8] = encA(OP_ST, 7, 8'hC1);
    im[9] = encA(OP_ST, 6, 8'hC2);
    runProg();
    check("R12 undefined leaves register", dm[8'hC0], 16'h0004);
    check("R12 undefined leaves rd field register", dm[8'hC1], 16'h0000);
    check("R12 undefined keeps flags", dm[8'hC2], 16'h0000);
    check("R12 undefined takes one cycle", 16'(runCyc), 16'd10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected halt");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    tReset();
    tArith();
    tLogic();
    tShift();
    tBranch();
    tHalt();
    tUndef();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule